// File: doc/BRIEF.md
# Priority Round-Robin Shared-Bus Arbiter and Slave Decoder

This block joins several bus masters to one shared Wishbone bus that serves up to sixteen slaves. A master asks for the bus by raising its CYC. When the bus is free, the block picks one requester and gives it the bus. It then carries that master's address, write data, byte selects and write enable onto the shared bus, and raises STB on exactly one slave, the one named by the upper address nibble. The acknowledge and the read data of that slave go back to the owning master only.

The choice of owner works in two steps. The block first finds the highest priority level among the current requesters. Among the requesters at that level, it then picks one with a rotating pointer. Each master's priority is a static configuration input. Once a master owns the bus it keeps it until it drops CYC, so a transfer is never cut short by a higher-priority request.

Top module: `prio_rr_bus_fabric`

## Requirements
- R1: At most one master sees its acknowledge high in any cycle, and the shared bus carries CYC only while a master owns it.
- R2: Priority field m of `prio_i` is bits [m*PW +: PW]. A larger value means higher priority. The requester with the highest value wins a free bus.
- R3: Among requesters tied at the top priority, the winner is the first one found at or after the rotation pointer, counting upward and wrapping. After a grant, the pointer moves to the master just above the winner. Reset sets the pointer to master 0.
- R4: An owner keeps the bus as long as it holds CYC high, whatever other masters request.
- R5: A grant takes effect in the cycle after the edge at which a request is seen on a free bus. That edge may be the one at which the previous owner's CYC is low. With no requester, the bus stays free.
- R6: The slave index is address bits [31:28]. Slave k gets STB only when the owner drives STB and the index equals k. An index of N_SLV or above strobes no slave.
- R7: The owner receives the addressed slave's acknowledge, gated by its own STB, and that slave's read data. Every other master sees acknowledge 0 and read data 0.
- R8: While a master owns the bus, its address, write data, byte selects and write enable appear on the shared bus outputs.
- R9: During reset no CYC, STB or acknowledge is driven, even if masters request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| prio_i | input | N_MST*PW | Per-master priority levels |
| m_cyc_i | input | N_MST | Master CYC (bus request) |
| m_stb_i | input | N_MST | Master STB |
| m_we_i | input | N_MST | Master write enable |
| m_adr_i | input | N_MST*AW | Master addresses |
| m_dat_i | input | N_MST*DW | Master write data |
| m_sel_i | input | N_MST*SW | Master byte selects |
| m_ack_o | output | N_MST | Acknowledge to each master |
| m_dat_o | output | N_MST*DW | Read data to each master |
| s_cyc_o | output | 1 | Shared CYC |
| s_stb_o | output | N_SLV | Per-slave STB |
| s_we_o | output | 1 | Shared write enable |
| s_adr_o | output | AW | Shared address |
| s_dat_o | output | DW | Shared write data |
| s_sel_o | output | SW | Shared byte selects |
| s_ack_i | input | N_SLV | Slave acknowledges |
| s_dat_i | input | N_SLV*DW | Slave read data |

## Verification
The bench walks a series of requests and checks how the rotation pointer moves. The series covers a full rotation, sparse request masks, a wrap past the top index, and ties beneath a higher level that has no requester. A pointer that is not updated, or that is applied before the priority filter, would pick the wrong winner. A higher-priority request is raised during an ongoing transfer; a design that pre-empts would hand the bus away early. The bench also looks at the release cycle, at STB held low by the owner, and at addresses that map past the last slave. A faulty design would grant late, strobe a phantom slave, or send a stray acknowledge to a master that does not own the bus.

// File: rtl/prfab_pkg.sv
package prfab_pkg;

   localparam int SLV_SEL_W = 4;

   function automatic int wrap_next(input int idx, input int n);
      return (idx + 1 >= n) ? 0 : idx + 1;
   endfunction

endpackage

// File: rtl/prfab_arbiter.sv
module prfab_arbiter #(
   parameter int N_MST = 4,
   parameter int PW    = 2,
   parameter bit RR_EN = 1'b1,
   parameter int IW    = 2
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [N_MST-1:0]      req_i,
   input  logic [N_MST*PW-1:0]   prio_i,
   output logic                  busy_o,
   output logic [IW-1:0]         own_o
);
   import prfab_pkg::*;

   logic              busy_q;
   logic [IW-1:0]     own_q;
   logic [IW-1:0]     ptr_q;
   logic [PW-1:0]     top_lvl;
   logic [N_MST-1:0]  tied;
   logic [IW-1:0]     win;
   logic              any_req;
   logic              free_bus;

   assign any_req  = |req_i;
   assign free_bus = !busy_q || !req_i[own_q];

   always_comb begin
      top_lvl = '0;
      for (int m = 0; m < N_MST; m++) begin
         if (req_i[m] && (prio_i[m*PW +: PW] > top_lvl)) top_lvl = prio_i[m*PW +: PW];
      end
      for (int m = 0; m < N_MST; m++) begin
         tied[m] = req_i[m] && (prio_i[m*PW +: PW] == top_lvl);
      end
   end

   generate
      if (RR_EN) begin : g_rotate
         always_comb begin
            logic found;
            int   idx;
            found = 1'b0;
            win   = '0;
            for (int k = 0; k < N_MST; k++) begin
               idx = int'(ptr_q) + k;
               if (idx >= N_MST) idx = idx - N_MST;
               if (!found && tied[idx]) begin
                  win   = IW'(idx);
                  found = 1'b1;
               end
            end
         end
      end else begin : g_fixed
         always_comb begin
            logic found;
            found = 1'b0;
            win   = '0;
            for (int k = 0; k < N_MST; k++) begin
               if (!found && tied[k]) begin
                  win   = IW'(k);
                  found = 1'b1;
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         own_q  <= '0;
         ptr_q  <= '0;
      end else if (free_bus) begin
         busy_q <= any_req;
         if (any_req) begin
            own_q <= win;
            ptr_q <= IW'(wrap_next(int'(win), N_MST));
         end
      end
   end

   assign busy_o = busy_q;
   assign own_o  = own_q;

endmodule

// File: rtl/prfab_decode.sv
module prfab_decode #(
   parameter int N_SLV = 12,
   parameter int AW    = 32,
   parameter int XW    = 4
) (
   input  logic [AW-1:0]    adr_i,
   input  logic             stb_en_i,
   output logic [N_SLV-1:0] stb_o,
   output logic [XW-1:0]    idx_o,
   output logic             hit_o
);
   assign idx_o = adr_i[AW-1 -: XW];
   assign hit_o = (int'(idx_o) < N_SLV);

   generate
      for (genvar s = 0; s < N_SLV; s++) begin : g_stb
         assign stb_o[s] = stb_en_i && (idx_o == XW'(s));
      end
   endgenerate

endmodule

// File: rtl/prfab_route.sv
module prfab_route #(
   parameter int N_MST = 4,
   parameter int N_SLV = 12,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int SW    = 4,
   parameter int IW    = 2,
   parameter int XW    = 4
) (
   input  logic                 busy_i,
   input  logic [IW-1:0]        own_i,
   input  logic [N_MST-1:0]     m_cyc_i,
   input  logic [N_MST-1:0]     m_stb_i,
   input  logic [N_MST-1:0]     m_we_i,
   input  logic [N_MST*AW-1:0]  m_adr_i,
   input  logic [N_MST*DW-1:0]  m_dat_i,
   input  logic [N_MST*SW-1:0]  m_sel_i,
   output logic [N_MST-1:0]     m_ack_o,
   output logic [N_MST*DW-1:0]  m_dat_o,
   input  logic [XW-1:0]        slv_idx_i,
   input  logic                 slv_hit_i,
   output logic                 own_stb_o,
   output logic                 s_cyc_o,
   output logic                 s_we_o,
   output logic [AW-1:0]        s_adr_o,
   output logic [DW-1:0]        s_dat_o,
   output logic [SW-1:0]        s_sel_o,
   input  logic [N_SLV-1:0]     s_ack_i,
   input  logic [N_SLV*DW-1:0]  s_dat_i
);
   logic          own_cyc;
   logic          ack_mux;
   logic [DW-1:0] dat_mux;

   assign own_cyc   = busy_i && m_cyc_i[own_i];
   assign own_stb_o = own_cyc && m_stb_i[own_i];

   assign s_cyc_o = own_cyc;
   assign s_we_o  = own_cyc && m_we_i[own_i];
   assign s_adr_o = own_cyc ? m_adr_i[int'(own_i)*AW +: AW] : '0;
   assign s_dat_o = own_cyc ? m_dat_i[int'(own_i)*DW +: DW] : '0;
   assign s_sel_o = own_cyc ? m_sel_i[int'(own_i)*SW +: SW] : '0;

   always_comb begin
      ack_mux = 1'b0;
      dat_mux = '0;
      for (int s = 0; s < N_SLV; s++) begin
         if (slv_hit_i && (slv_idx_i == XW'(s))) begin
            ack_mux = s_ack_i[s];
            dat_mux = s_dat_i[s*DW +: DW];
         end
      end
   end

   generate
      for (genvar m = 0; m < N_MST; m++) begin : g_ret
         logic mine;
         assign mine                 = own_cyc && (own_i == IW'(m));
         assign m_ack_o[m]           = mine && own_stb_o && ack_mux;
         assign m_dat_o[m*DW +: DW]  = mine ? dat_mux : '0;
      end
   endgenerate

endmodule

// File: rtl/prio_rr_bus_fabric.sv
module prio_rr_bus_fabric #(
   parameter int N_MST = 4,
   parameter int N_SLV = 12,
   parameter int PW    = 2,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter bit RR_EN = 1'b1,
   localparam int SW   = DW / 8,
   localparam int IW   = (N_MST > 1) ? $clog2(N_MST) : 1,
   localparam int XW   = prfab_pkg::SLV_SEL_W
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [N_MST*PW-1:0]  prio_i,
   input  logic [N_MST-1:0]     m_cyc_i,
   input  logic [N_MST-1:0]     m_stb_i,
   input  logic [N_MST-1:0]     m_we_i,
   input  logic [N_MST*AW-1:0]  m_adr_i,
   input  logic [N_MST*DW-1:0]  m_dat_i,
   input  logic [N_MST*SW-1:0]  m_sel_i,
   output logic [N_MST-1:0]     m_ack_o,
   output logic [N_MST*DW-1:0]  m_dat_o,
   output logic                 s_cyc_o,
   output logic [N_SLV-1:0]     s_stb_o,
   output logic                 s_we_o,
   output logic [AW-1:0]        s_adr_o,
   output logic [DW-1:0]        s_dat_o,
   output logic [SW-1:0]        s_sel_o,
   input  logic [N_SLV-1:0]     s_ack_i,
   input  logic [N_SLV*DW-1:0]  s_dat_i
);
   initial begin
      assert (N_SLV >= 1 && N_SLV <= (1 << XW)) else $fatal(1, "N_SLV out of range");
      assert (N_MST >= 1) else $fatal(1, "N_MST must be positive");
      assert (AW > XW && DW % 8 == 0) else $fatal(1, "bad bus widths");
      assert (PW >= 1) else $fatal(1, "PW must be positive");
   end

   logic          arb_busy;
   logic [IW-1:0] arb_own;
   logic          own_stb;
   logic [XW-1:0] slv_idx;
   logic          slv_hit;

   prfab_arbiter #(.N_MST(N_MST), .PW(PW), .RR_EN(RR_EN), .IW(IW)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (m_cyc_i),
      .prio_i (prio_i),
      .busy_o (arb_busy),
      .own_o  (arb_own)
   );

   prfab_route #(.N_MST(N_MST), .N_SLV(N_SLV), .AW(AW), .DW(DW), .SW(SW), .IW(IW), .XW(XW)) u_route (
      .busy_i    (arb_busy),
      .own_i     (arb_own),
      .m_cyc_i   (m_cyc_i),
      .m_stb_i   (m_stb_i),
      .m_we_i    (m_we_i),
      .m_adr_i   (m_adr_i),
      .m_dat_i   (m_dat_i),
      .m_sel_i   (m_sel_i),
      .m_ack_o   (m_ack_o),
      .m_dat_o   (m_dat_o),
      .slv_idx_i (slv_idx),
      .slv_hit_i (slv_hit),
      .own_stb_o (own_stb),
      .s_cyc_o   (s_cyc_o),
      .s_we_o    (s_we_o),
      .s_adr_o   (s_adr_o),
      .s_dat_o   (s_dat_o),
      .s_sel_o   (s_sel_o),
      .s_ack_i   (s_ack_i),
      .s_dat_i   (s_dat_i)
   );

   prfab_decode #(.N_SLV(N_SLV), .AW(AW), .XW(XW)) u_dec (
      .adr_i    (s_adr_o),
      .stb_en_i (own_stb),
      .stb_o    (s_stb_o),
      .idx_o    (slv_idx),
      .hit_o    (slv_hit)
   );

endmodule

// File: rtl/prfab_checker.sv
module prfab_checker #(
   parameter int N_MST = 4,
   parameter int N_SLV = 12,
   parameter int IW    = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [N_MST-1:0] m_cyc_i,
   input logic [N_MST-1:0] m_ack_o,
   input logic [N_SLV-1:0] s_stb_o,
   input logic             s_cyc_o,
   input logic             arb_busy,
   input logic [IW-1:0]    arb_own
);
   assert_single_ack_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(m_ack_o));

   assert_cyc_needs_owner_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_cyc_o |-> arb_busy);

   assert_owner_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (arb_busy && m_cyc_i[arb_own]) |=> (arb_busy && arb_own == $past(arb_own)));

   assert_free_grant_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!arb_busy && m_cyc_i != '0) |=> arb_busy);

   assert_stays_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m_cyc_i == '0) |=> !arb_busy);

   assert_one_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(s_stb_o));

   assert_strobe_in_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s_stb_o != '0) |-> s_cyc_o);

   assert_ack_to_owner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m_ack_o != '0) |-> (arb_busy && m_ack_o[arb_own]));

endmodule

bind prio_rr_bus_fabric prfab_checker #(.N_MST(N_MST), .N_SLV(N_SLV), .IW(IW)) u_prfab_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .m_cyc_i  (m_cyc_i),
   .m_ack_o  (m_ack_o),
   .s_stb_o  (s_stb_o),
   .s_cyc_o  (s_cyc_o),
   .arb_busy (arb_busy),
   .arb_own  (arb_own)
);

// File: tb/prio_rr_bus_fabric_bench.sv
module prio_rr_bus_fabric_bench;
   localparam int NM = 4;
   localparam int NS = 12;
   localparam int PW = 2;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam int SW = 4;

   logic              clk_i = 1'b0;
   logic              rst_ni = 1'b0;
   logic [NM*PW-1:0]  prio_i = '0;
   logic [NM-1:0]     m_cyc_i = '0, m_stb_i = '0, m_we_i = '0;
   logic [NM*AW-1:0]  m_adr_i = '0;
   logic [NM*DW-1:0]  m_dat_i = '0;
   logic [NM*SW-1:0]  m_sel_i = '0;
   logic [NM-1:0]     m_ack_o;
   logic [NM*DW-1:0]  m_dat_o;
   logic              s_cyc_o;
   logic [NS-1:0]     s_stb_o;
   logic              s_we_o;
   logic [AW-1:0]     s_adr_o;
   logic [DW-1:0]     s_dat_o;
   logic [SW-1:0]     s_sel_o;
   logic [NS-1:0]     s_ack_i = '1;
   logic [NS*DW-1:0]  s_dat_i;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #10 clk_i = ~clk_i;

   for (genvar k = 0; k < NS; k++) begin : g_sdat
      assign s_dat_i[k*DW +: DW] = 32'h5A00_0000 + k;
   end

   prio_rr_bus_fabric #(.N_MST(NM), .N_SLV(NS), .PW(PW), .AW(AW), .DW(DW)) u_prio_rr_bus_fabric (
      .clk_i(clk_i), .rst_ni(rst_ni), .prio_i(prio_i),
      .m_cyc_i(m_cyc_i), .m_stb_i(m_stb_i), .m_we_i(m_we_i),
      .m_adr_i(m_adr_i), .m_dat_i(m_dat_i), .m_sel_i(m_sel_i),
      .m_ack_o(m_ack_o), .m_dat_o(m_dat_o),
      .s_cyc_o(s_cyc_o), .s_stb_o(s_stb_o), .s_we_o(s_we_o),
      .s_adr_o(s_adr_o), .s_dat_o(s_dat_o), .s_sel_o(s_sel_o),
      .s_ack_i(s_ack_i), .s_dat_i(s_dat_i)
   );

   // {priority fields (m3..m0), request mask, expected winner}
   localparam logic [15:0] VEC [0:11] = '{
      {8'h00, 4'b1111, 4'd0}, {8'h00, 4'b1111, 4'd1},
      {8'h00, 4'b1111, 4'd2}, {8'h00, 4'b1111, 4'd3},
      {8'h00, 4'b1010, 4'd1}, {8'h00, 4'b1010, 4'd3},
      {8'h30, 4'b1111, 4'd2}, {8'h1A, 4'b1111, 4'd0},
      {8'h1A, 4'b1111, 4'd1}, {8'h1A, 4'b1111, 4'd0},
      {8'hD5, 4'b0111, 4'd1}, {8'h00, 4'b0001, 4'd0}
   };

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive_master(input int m, input bit cyc, input bit stb, input logic [3:0] slot);
      m_cyc_i[m] = cyc;
      m_stb_i[m] = stb;
      m_we_i[m]  = m[0];
      m_adr_i[m*AW +: AW] = {slot, 20'h0, 8'(m)};
      m_dat_i[m*DW +: DW] = 32'hD0 + m;
      m_sel_i[m*SW +: SW] = SW'(1 << m);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [NM*DW-1:0] exp_dat;
      // R9: requests during reset are not granted
      drive_master(1, 1'b1, 1'b1, 4'd5);
      repeat (2) @(posedge clk_i);
      @(negedge clk_i);
      chk(s_cyc_o == 1'b0 && s_stb_o == '0 && m_ack_o == '0, "R9",
          {s_cyc_o, s_stb_o, m_ack_o}, 0);
      drive_master(1, 1'b0, 1'b0, 4'd5);
      rst_ni = 1'b1;
      @(posedge clk_i);

      // Table walk: R2 priority, R3 rotation, R6/R7/R8 routing
      for (int i = 0; i < 12; i++) begin
         logic [3:0] w;
         @(negedge clk_i);
         w = VEC[i][3:0];
         prio_i = VEC[i][15:8];
         for (int m = 0; m < NM; m++) drive_master(m, VEC[i][4+m], VEC[i][4+m], 4'(m + 4));
         @(posedge clk_i);
         @(negedge clk_i);
         chk(s_cyc_o && s_adr_o[7:0] == 8'(w), "R2/R3 winner", s_adr_o[7:0], w);
         chk(s_stb_o == NS'(1 << (w + 4)), "R6 strobe", s_stb_o, NS'(1 << (w + 4)));
         chk(m_ack_o == NM'(1 << w), "R7 ack", m_ack_o, NM'(1 << w));
         exp_dat = '0;
         exp_dat[w*DW +: DW] = 32'h5A00_0000 + w + 4;
         chk(m_dat_o == exp_dat, "R7 read data", m_dat_o, exp_dat);
         chk(s_dat_o == 32'hD0 + w && s_we_o == w[0] && s_sel_o == SW'(1 << w), "R8 routing",
             {s_dat_o, s_we_o, s_sel_o}, {32'hD0 + w, w[0], SW'(1 << w)});
         chk($onehot0(m_ack_o) && s_cyc_o, "R1", m_ack_o, NM'(1 << w));
         for (int m = 0; m < NM; m++) drive_master(m, 1'b0, 1'b0, 4'(m + 4));
         @(posedge clk_i);
      end

      // R4: no pre-emption by a higher-priority request
      @(negedge clk_i);
      prio_i = 8'h03;
      drive_master(2, 1'b1, 1'b1, 4'd6);
      @(posedge clk_i);
      @(negedge clk_i);
      chk(s_adr_o[7:0] == 8'd2, "R5 grant on free bus", s_adr_o[7:0], 2);
      drive_master(0, 1'b1, 1'b1, 4'd4);
      repeat (3) @(posedge clk_i);
      @(negedge clk_i);
      chk(s_adr_o[7:0] == 8'd2 && m_ack_o == 4'b0100, "R4 hold", {s_adr_o[7:0], m_ack_o}, {8'd2, 4'b0100});
      // R5: release cycle, then handover on the next edge
      drive_master(2, 1'b0, 1'b0, 4'd6);
      #1;
      chk(s_cyc_o == 1'b0 && m_ack_o == '0, "R5 release", {s_cyc_o, m_ack_o}, 0);
      @(posedge clk_i);
      @(negedge clk_i);
      chk(s_cyc_o && s_adr_o[7:0] == 8'd0 && m_ack_o == 4'b0001, "R5 handover",
          {s_adr_o[7:0], m_ack_o}, {8'd0, 4'b0001});

      // R6/R7: owner STB low -> no strobe, no ack
      m_stb_i[0] = 1'b0;
      #1;
      chk(s_stb_o == '0 && m_ack_o == '0, "R6 stb gating", {s_stb_o, m_ack_o}, 0);
      // R6: index 14 is past the last slave
      drive_master(0, 1'b1, 1'b1, 4'd14);
      #1;
      chk(s_stb_o == '0 && m_ack_o == '0 && m_dat_o == '0, "R6 unmapped", {s_stb_o, m_ack_o}, 0);
      drive_master(0, 1'b1, 1'b1, 4'd11);
      #1;
      chk(s_stb_o == NS'(1 << 11) && m_ack_o == 4'b0001, "R6 last slave",
          {s_stb_o, m_ack_o}, {NS'(1 << 11), 4'b0001});

      // R5: no requester keeps the bus free
      drive_master(0, 1'b0, 1'b0, 4'd4);
      repeat (2) @(posedge clk_i);
      @(negedge clk_i);
      chk(s_cyc_o == 1'b0 && m_ack_o == '0 && s_stb_o == '0, "R5 idle", {s_cyc_o, m_ack_o}, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule